// File: doc/BRIEF.md
# Synchronous Character Hunt Detector

This block is the receive-side alignment logic of a synchronous serial receiver. It takes a stream of received bits, each marked by a one-cycle valid strobe. In hunt mode it compares the most recent character-length window of bits against one programmed sync pattern, or against two patterns that must arrive back to back. When the sync condition is met, the block leaves hunt mode and raises a sync-detect status flag. From then on it cuts the stream into characters and emits a one-cycle boundary strobe, together with the assembled character, toward the receive data path.

The block can also take character alignment from an external sync-detect input instead of its own comparison. In that mode the internal comparators are ignored, and a rising edge on the external input sets the status flag and ends the hunt. The flag clears when the host reads status. An enter-hunt command refills the hunt register with ones, so that bits received earlier cannot take part in a match, and restarts the search.

Top module: `sync_hunt_detector`

## Requirements
- R1: After reset `syndet` is 0, `hunting` is 1, `char_strobe` is 0 and `char_data` is 0.
- R2: The character length is N = 5 + `cfg_char_len` (code 0 gives 5 bits, code 3 gives 8 bits). Bits arrive least significant bit first. The compared or delivered character holds the last N accepted bits, with the earliest of them in bit 0 and the upper bits zero.
- R3: With `cfg_double_sync`=0 and `cfg_ext_sync`=0, while hunting, a match of the window with `sync_pat_a[N-1:0]` is tested at every accepted bit, at any alignment. A match clears `hunting` and sets `syndet` at the clock edge that accepts the completing bit.
- R4: With `cfg_double_sync`=1, a match on `sync_pat_a` arms a second compare. That compare is taken on exactly the N-th accepted bit after the first match and must equal `sync_pat_b`. If it fails, the hunt goes on, and that same window is tested again against `sync_pat_a`.
- R5: `cmd_enter_hunt` sets `hunting` and fills the hunt register with ones at the next edge. A bit accepted in the same cycle is discarded, and `syndet` is unchanged.
- R6: With `cfg_ext_sync`=1, the internal compare never ends the hunt. A rising edge of `ext_sync_in` (low in the previous cycle, high now) sets `syndet` and, while hunting, clears `hunting`.
- R7: A `status_read` pulse clears `syndet` at the next edge. A sync event in the same cycle takes priority, and `syndet` is then set.
- R8: Once the hunt has ended, every N-th accepted bit produces a one-cycle `char_strobe`, with `char_data` holding that character. The strobe is visible after the edge that accepts the N-th bit. Bit counting starts with the first bit accepted after the cycle that ended the hunt. No strobe is produced while hunting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_bit_valid | input | 1 | One-cycle strobe: `rx_bit` holds a new received bit |
| rx_bit | input | 1 | Received serial bit |
| cfg_char_len | input | 2 | Character length code, N = 5 + code |
| cfg_double_sync | input | 1 | 1: two sync characters in sequence are required |
| cfg_ext_sync | input | 1 | 1: alignment is taken from `ext_sync_in` |
| sync_pat_a | input | 8 | First (or only) sync pattern |
| sync_pat_b | input | 8 | Second sync pattern |
| cmd_enter_hunt | input | 1 | One-cycle enter-hunt command |
| ext_sync_in | input | 1 | External sync-detect input, synchronous to `clk` |
| status_read | input | 1 | One-cycle pulse marking a host status read |
| syndet | output | 1 | Sync-detect status flag |
| hunting | output | 1 | 1 while searching for alignment |
| char_strobe | output | 1 | Character-boundary strobe |
| char_data | output | 8 | Last framed character |

## Verification
Every result of this block is due one clock edge after its cause. `hunting` and `syndet` change at the edge that accepts the completing bit, or that samples the external edge, the command or the status read. `char_strobe` and `char_data` appear after the edge that accepts the N-th bit of a character. The bench drives inputs on falling edges. Its reference model steps on the same rising edge as the design, and the outputs are compared against the model on every falling edge. The directed checks in the scenarios are also taken on the falling edge right after the bit or pulse that causes them, so each result is sampled in the cycle it is due.

// File: rtl/sh_pkg.sv
// Package: shared types for the synchronous character hunt detector.
// Assumes: nothing beyond IEEE 1800-2017.
package sh_pkg;

    // Hunt progress while searching for one or two sync characters.
    typedef enum logic {
        PH_FIRST  = 1'b0,   // looking for the first sync pattern
        PH_SECOND = 1'b1    // first pattern found, collecting the second
    } hunt_phase_e;

endpackage

// File: rtl/sh_hunt_shreg.sv
// Module: sh_hunt_shreg
// Holds the last MAX_W received bits (newest in the MSB) and presents the
// character-length window that the register will hold once the current bit
// has been shifted in, aligned so that the earliest bit sits at bit 0.
// Assumes: char_len is between 1 and MAX_W and is stable while bits arrive.
module sh_hunt_shreg #(
    parameter int MAX_W = 8,
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             preset,
    input  logic             shift_en,
    input  logic             bit_in,
    input  logic [LEN_W-1:0] char_len,
    output logic [MAX_W-1:0] window
);

    logic [MAX_W-1:0] sr_q;
    logic [MAX_W-1:0] sr_next;
    logic [LEN_W-1:0] shift_amt;

    // Value the register takes when the current bit is accepted.
    always_comb begin
        sr_next   = {bit_in, sr_q[MAX_W-1:1]};
        shift_amt = LEN_W'(MAX_W) - char_len;
        window    = sr_next >> shift_amt;
    end

    // Shift register: all ones at reset and on preset, shifts on each bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '1;
        end else if (preset) begin
            sr_q <= '1;
        end else if (shift_en) begin
            sr_q <= sr_next;
        end
    end

endmodule

// File: rtl/sh_sync_cmp.sv
// Module: sh_sync_cmp
// Compares the aligned window with each programmed sync pattern, masked to
// the character length. Purely combinational.
// Assumes: window bits at and above char_len are zero.
module sh_sync_cmp #(
    parameter int MAX_W    = 8,
    parameter int LEN_W    = 4,
    parameter int NUM_SYNC = 2
) (
    input  logic [NUM_SYNC-1:0][MAX_W-1:0] patterns,
    input  logic [MAX_W-1:0]               window,
    input  logic [LEN_W-1:0]               char_len,
    output logic [NUM_SYNC-1:0]            hit
);

    logic [MAX_W-1:0] len_mask;
    logic [LEN_W-1:0] shift_amt;

    // Mask that keeps the low char_len bits of a pattern.
    always_comb begin
        shift_amt = LEN_W'(MAX_W) - char_len;
        len_mask  = {MAX_W{1'b1}} >> shift_amt;
    end

    // One equality comparator per sync pattern.
    for (genvar g = 0; g < NUM_SYNC; g++) begin : g_cmp
        always_comb begin
            hit[g] = (window == (patterns[g] & len_mask));
        end
    end

endmodule

// File: rtl/sh_hunt_ctrl.sv
// Module: sh_hunt_ctrl
// Hunt control: tracks single or double sync progress, detects external
// sync edges, owns the hunting state and the sync-detect status flag.
// Assumes: hit[0] is the first pattern, hit[1] the second, both valid in a
// cycle with bit_valid; ext_sync_in is already synchronous to clk.
module sh_hunt_ctrl
    import sh_pkg::*;
#(
    parameter int LEN_W = 4,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enter_hunt,
    input  logic             bit_valid,
    input  logic             ext_mode,
    input  logic             double_mode,
    input  logic             ext_sync_in,
    input  logic             status_read,
    input  logic [1:0]       hit,
    input  logic [LEN_W-1:0] char_len,
    output logic             hunting,
    output logic             syndet,
    output logic             sync_found
);

    hunt_phase_e      phase_q;
    logic [CNT_W-1:0] pcnt_q;
    logic             hunting_q;
    logic             syndet_q;
    logic             ext_q;

    logic             ext_edge;
    logic             int_check;
    logic             second_done;
    logic             int_found;
    logic             ext_found;

    // Event decode for the current cycle.
    always_comb begin
        ext_edge    = ext_mode & ext_sync_in & ~ext_q;
        int_check   = hunting_q & ~ext_mode & bit_valid & ~enter_hunt;
        second_done = (phase_q == PH_SECOND) &&
                      (pcnt_q == CNT_W'(char_len - LEN_W'(1)));
        int_found   = int_check &
                      (((phase_q == PH_FIRST) & hit[0] & ~double_mode) |
                       (second_done & hit[1]));
        ext_found   = ext_edge & hunting_q & ~enter_hunt;
        sync_found  = int_found | ext_found;
    end

    // Previous external input level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_q <= 1'b0;
        end else begin
            ext_q <= ext_sync_in;
        end
    end

    // Double-sync progress: phase and bit count after the first pattern.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_FIRST;
            pcnt_q  <= '0;
        end else if (enter_hunt || sync_found) begin
            phase_q <= PH_FIRST;
            pcnt_q  <= '0;
        end else if (int_check) begin
            if (phase_q == PH_FIRST) begin
                if (hit[0] && double_mode) begin
                    phase_q <= PH_SECOND;
                    pcnt_q  <= '0;
                end
            end else if (second_done) begin
                phase_q <= hit[0] ? PH_SECOND : PH_FIRST;
                pcnt_q  <= '0;
            end else begin
                pcnt_q <= pcnt_q + CNT_W'(1);
            end
        end
    end

    // Hunting state: set by command, cleared when sync is found.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hunting_q <= 1'b1;
        end else if (enter_hunt) begin
            hunting_q <= 1'b1;
        end else if (sync_found) begin
            hunting_q <= 1'b0;
        end
    end

    // Sync-detect flag: set by any sync event, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            syndet_q <= 1'b0;
        end else if (int_found || ext_edge) begin
            syndet_q <= 1'b1;
        end else if (status_read) begin
            syndet_q <= 1'b0;
        end
    end

    assign hunting = hunting_q;
    assign syndet  = syndet_q;

endmodule

// File: rtl/sh_char_framer.sv
// Module: sh_char_framer
// Counts accepted bits once alignment is held and emits a boundary strobe
// with the assembled character every char_len bits.
// Assumes: restart is a one-cycle pulse in the cycle the hunt ends.
module sh_char_framer #(
    parameter int MAX_W = 8,
    parameter int LEN_W = 4,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             enter_hunt,
    input  logic             hunting,
    input  logic             bit_valid,
    input  logic [MAX_W-1:0] window,
    input  logic [LEN_W-1:0] char_len,
    output logic             char_strobe,
    output logic [MAX_W-1:0] char_data
);

    logic [CNT_W-1:0] fcnt_q;
    logic             count_en;
    logic             last_bit;
    logic             strobe_q;
    logic [MAX_W-1:0] data_q;

    // Decode of a counted bit and of the last bit of a character.
    always_comb begin
        count_en = ~hunting & bit_valid & ~enter_hunt;
        last_bit = (fcnt_q == CNT_W'(char_len - LEN_W'(1)));
    end

    // Bit position inside the current character.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcnt_q <= '0;
        end else if (restart) begin
            fcnt_q <= '0;
        end else if (count_en) begin
            fcnt_q <= last_bit ? '0 : fcnt_q + CNT_W'(1);
        end
    end

    // Boundary strobe and held character.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
            data_q   <= '0;
        end else begin
            strobe_q <= count_en & last_bit & ~restart;
            if (count_en && last_bit && !restart) begin
                data_q <= window;
            end
        end
    end

    assign char_strobe = strobe_q;
    assign char_data   = data_q;

endmodule

// File: rtl/sync_hunt_detector.sv
// Module: sync_hunt_detector (top)
// Synchronous-mode receive alignment: hunts for one or two sync characters
// or takes an external sync event, reports sync-detect status with
// clear-on-read, then frames characters of 5 to MAX_W bits.
// Assumes: configuration inputs are static while bits arrive; one bit per
// rx_bit_valid pulse; all inputs synchronous to clk.
module sync_hunt_detector #(
    parameter int MAX_W      = 8,
    parameter int MIN_W      = 5,
    parameter int LEN_CODE_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rx_bit_valid,
    input  logic                  rx_bit,
    input  logic [LEN_CODE_W-1:0] cfg_char_len,
    input  logic                  cfg_double_sync,
    input  logic                  cfg_ext_sync,
    input  logic [MAX_W-1:0]      sync_pat_a,
    input  logic [MAX_W-1:0]      sync_pat_b,
    input  logic                  cmd_enter_hunt,
    input  logic                  ext_sync_in,
    input  logic                  status_read,
    output logic                  syndet,
    output logic                  hunting,
    output logic                  char_strobe,
    output logic [MAX_W-1:0]      char_data
);

    localparam int LEN_W    = $clog2(MAX_W + 1);
    localparam int CNT_W    = $clog2(MAX_W);
    localparam int NUM_SYNC = 2;

    logic [LEN_W-1:0]              char_len;
    logic [MAX_W-1:0]              window;
    logic [NUM_SYNC-1:0][MAX_W-1:0] patterns;
    logic [NUM_SYNC-1:0]           hit;
    logic                          sync_found;
    logic                          hunting_i;

    // Character length in bits and the pattern bank.
    always_comb begin
        char_len    = LEN_W'(MIN_W) + LEN_W'(cfg_char_len);
        patterns[0] = sync_pat_a;
        patterns[1] = sync_pat_b;
    end

    sh_hunt_shreg #(
        .MAX_W (MAX_W),
        .LEN_W (LEN_W)
    ) u_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .preset   (cmd_enter_hunt),
        .shift_en (rx_bit_valid),
        .bit_in   (rx_bit),
        .char_len (char_len),
        .window   (window)
    );

    sh_sync_cmp #(
        .MAX_W    (MAX_W),
        .LEN_W    (LEN_W),
        .NUM_SYNC (NUM_SYNC)
    ) u_cmp (
        .patterns (patterns),
        .window   (window),
        .char_len (char_len),
        .hit      (hit)
    );

    sh_hunt_ctrl #(
        .LEN_W (LEN_W),
        .CNT_W (CNT_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .enter_hunt  (cmd_enter_hunt),
        .bit_valid   (rx_bit_valid),
        .ext_mode    (cfg_ext_sync),
        .double_mode (cfg_double_sync),
        .ext_sync_in (ext_sync_in),
        .status_read (status_read),
        .hit         (hit),
        .char_len    (char_len),
        .hunting     (hunting_i),
        .syndet      (syndet),
        .sync_found  (sync_found)
    );

    sh_char_framer #(
        .MAX_W (MAX_W),
        .LEN_W (LEN_W),
        .CNT_W (CNT_W)
    ) u_framer (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (sync_found),
        .enter_hunt  (cmd_enter_hunt),
        .hunting     (hunting_i),
        .bit_valid   (rx_bit_valid),
        .window      (window),
        .char_len    (char_len),
        .char_strobe (char_strobe),
        .char_data   (char_data)
    );

    assign hunting = hunting_i;

endmodule

// File: rtl/sh_hunt_checker.sv
// Module: sh_hunt_checker
// Protocol properties of the hunt detector, observed at its ports.
// Assumes: bound to sync_hunt_detector, all checks disabled in reset.
module sh_hunt_checker (
    input logic clk,
    input logic rst_n,
    input logic cfg_ext_sync,
    input logic cmd_enter_hunt,
    input logic status_read,
    input logic syndet,
    input logic hunting,
    input logic char_strobe
);

    // R8: no boundary strobe while hunting
    assert_no_strobe_in_hunt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        char_strobe |-> !hunting);

    // R8: a strobe lasts one cycle
    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        char_strobe |=> !char_strobe);

    // R5: the command always leads to hunting
    assert_enter_hunt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_enter_hunt |=> hunting);

    // R5: hunting only restarts through the command
    assert_hunt_only_by_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hunting) |-> $past(cmd_enter_hunt));

    // R3: the hunt never ends without the sync flag
    assert_hunt_end_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hunting) |-> syndet);

    // R7: a read with no possible sync event clears the flag
    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_read && !hunting && !cfg_ext_sync) |=> !syndet);

endmodule

bind sync_hunt_detector sh_hunt_checker u_sh_hunt_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_ext_sync   (cfg_ext_sync),
    .cmd_enter_hunt (cmd_enter_hunt),
    .status_read    (status_read),
    .syndet         (syndet),
    .hunting        (hunting),
    .char_strobe    (char_strobe)
);

// File: tb/sync_hunt_detector_bench.sv
// Bench: behavioural reference model compared on every clock, plus
// directed checks for each requirement.
module sync_hunt_detector_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_bit_valid = 1'b0;
    logic       rx_bit = 1'b0;
    logic [1:0] cfg_char_len = 2'd3;
    logic       cfg_double_sync = 1'b0;
    logic       cfg_ext_sync = 1'b0;
    logic [7:0] sync_pat_a = 8'h16;
    logic [7:0] sync_pat_b = 8'h27;
    logic       cmd_enter_hunt = 1'b0;
    logic       ext_sync_in = 1'b0;
    logic       status_read = 1'b0;
    logic       syndet;
    logic       hunting;
    logic       char_strobe;
    logic [7:0] char_data;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    sync_hunt_detector u_sync_hunt_detector (
        .clk             (clk),
        .rst_n           (rst_n),
        .rx_bit_valid    (rx_bit_valid),
        .rx_bit          (rx_bit),
        .cfg_char_len    (cfg_char_len),
        .cfg_double_sync (cfg_double_sync),
        .cfg_ext_sync    (cfg_ext_sync),
        .sync_pat_a      (sync_pat_a),
        .sync_pat_b      (sync_pat_b),
        .cmd_enter_hunt  (cmd_enter_hunt),
        .ext_sync_in     (ext_sync_in),
        .status_read     (status_read),
        .syndet          (syndet),
        .hunting         (hunting),
        .char_strobe     (char_strobe),
        .char_data       (char_data)
    );

    // ---------------- reference model ----------------
    int hist[$];
    int m_hunt, m_syn, m_phase, m_pcnt, m_fcnt, m_strobe, m_data, m_ext_prev;

    function automatic int win(int n);
        int w = 0;
        for (int i = 0; i < n; i++) w |= hist[8 - n + i] << i;
        return w;
    endfunction

    task automatic fill_ones();
        hist = {};
        for (int i = 0; i < 8; i++) hist.push_back(1);
    endtask

    always @(posedge clk) begin
        int n, w, s1, s2, ev, found;
        if (!rst_n) begin
            fill_ones();
            m_hunt = 1; m_syn = 0; m_phase = 0; m_pcnt = 0;
            m_fcnt = 0; m_strobe = 0; m_data = 0; m_ext_prev = 0;
        end else begin
            n  = 5 + int'(cfg_char_len);
            s1 = int'(sync_pat_a) & ((1 << n) - 1);
            s2 = int'(sync_pat_b) & ((1 << n) - 1);
            ev = (cfg_ext_sync && ext_sync_in && !m_ext_prev) ? 1 : 0;
            m_ext_prev = int'(ext_sync_in);
            found = 0;
            m_strobe = 0;
            if (cmd_enter_hunt) begin
                fill_ones();
                m_hunt = 1; m_phase = 0; m_pcnt = 0;
            end else begin
                if (rx_bit_valid) begin
                    hist.push_back(int'(rx_bit));
                    void'(hist.pop_front());
                    w = win(n);
                    if (m_hunt && !cfg_ext_sync) begin
                        if (m_phase == 0) begin
                            if (w == s1) begin
                                if (cfg_double_sync) begin m_phase = 1; m_pcnt = 0; end
                                else found = 1;
                            end
                        end else if (m_pcnt == n - 1) begin
                            if (w == s2) found = 1;
                            else if (w == s1) m_pcnt = 0;
                            else begin m_phase = 0; m_pcnt = 0; end
                        end else m_pcnt++;
                    end else if (!m_hunt) begin
                        if (m_fcnt == n - 1) begin
                            m_strobe = 1; m_data = w; m_fcnt = 0;
                        end else m_fcnt++;
                    end
                end
                if (ev && m_hunt) found = 1;
            end
            if (found) begin m_hunt = 0; m_fcnt = 0; m_phase = 0; end
            if (found || ev) m_syn = 1;
            else if (status_read) m_syn = 0;
        end
    end

    // Every-clock comparison with the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (hunting !== m_hunt[0] || syndet !== m_syn[0] ||
                char_strobe !== m_strobe[0] ||
                char_data !== m_data[7:0]) begin
                fails++;
                $display("FAIL R3/R7/R8 model: hunt=%0b syn=%0b stb=%0b data=%02h expected hunt=%0d syn=%0d stb=%0d data=%02h",
                         hunting, syndet, char_strobe, char_data,
                         m_hunt, m_syn, m_strobe, m_data);
            end
        end
    end

    // ---------------- directed checks ----------------
    task automatic check(string req, int actual, int expected);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, actual, expected);
        end
    endtask

    task automatic send_bit(logic b);
        @(negedge clk); rx_bit_valid = 1'b1; rx_bit = b;
        @(negedge clk); rx_bit_valid = 1'b0;
    endtask

    task automatic send_char(int v, int n);
        for (int i = 0; i < n; i++) send_bit(v[i]);
    endtask

    task automatic enter_hunt();
        @(negedge clk); cmd_enter_hunt = 1'b1;
        @(negedge clk); cmd_enter_hunt = 1'b0;
    endtask

    task automatic read_status();
        @(negedge clk); status_read = 1'b1;
        @(negedge clk); status_read = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual expired expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 syndet", syndet, 0);
        check("R1 hunting", hunting, 1);
        check("R1 strobe", char_strobe, 0);
        check("R1 data", char_data, 0);

        // R3/R8/R2: single 8-bit sync after junk, then two characters
        send_bit(1); send_bit(0); send_bit(1);
        check("R3 still hunting", hunting, 1);
        send_char(8'h16, 8);
        check("R3 hunt ended", hunting, 0);
        check("R3 syndet", syndet, 1);
        send_char(8'hA5, 8);
        check("R8 strobe", char_strobe, 1);
        check("R2 data A5", char_data, 8'hA5);
        @(negedge clk);
        check("R8 strobe one cycle", char_strobe, 0);
        send_char(8'h3C, 8);
        check("R2 data 3C", char_data, 8'h3C);

        // R7: status read clears
        read_status();
        check("R7 cleared", syndet, 0);

        // R2: 5-bit characters
        cfg_char_len = 2'd0; sync_pat_a = 8'h15;
        enter_hunt();
        send_char(5'h15, 5);
        check("R2 5-bit sync", hunting, 0);
        send_char(5'h0A, 5);
        check("R2 5-bit strobe", char_strobe, 1);
        check("R2 5-bit data", char_data, 8'h0A);

        // R4: double sync, gap bit fails, back-to-back succeeds
        cfg_char_len = 2'd3; sync_pat_a = 8'h16; sync_pat_b = 8'h27;
        cfg_double_sync = 1'b1;
        read_status();
        enter_hunt();
        send_char(8'h16, 8);
        check("R4 one pattern only", hunting, 1);
        send_bit(0);
        send_char(8'h27, 8);
        check("R4 gap rejected", hunting, 1);
        check("R4 gap no syndet", syndet, 0);
        send_char(8'h16, 8);
        send_char(8'h27, 8);
        check("R4 pair found", hunting, 0);
        check("R4 syndet", syndet, 1);
        // R4: repeated first pattern re-arms
        enter_hunt();
        check("R5 syndet kept", syndet, 1);
        read_status();
        send_char(8'h16, 8); send_char(8'h16, 8);
        check("R4 after A,A", hunting, 1);
        send_char(8'h27, 8);
        check("R4 A,A,B found", hunting, 0);

        // R5: preset to ones and discard of same-cycle bit
        cfg_double_sync = 1'b0; sync_pat_a = 8'h00;
        read_status();
        @(negedge clk); cmd_enter_hunt = 1'b1; rx_bit_valid = 1'b1; rx_bit = 1'b0;
        @(negedge clk); cmd_enter_hunt = 1'b0; rx_bit_valid = 1'b0;
        for (int i = 0; i < 4; i++) send_bit(0);
        enter_hunt();
        for (int i = 0; i < 7; i++) send_bit(0);
        check("R5 stale bits ignored", hunting, 1);
        send_bit(0);
        check("R5 match after 8 zeros", hunting, 0);

        // R6: external sync mode
        cfg_ext_sync = 1'b1; sync_pat_a = 8'h16;
        read_status();
        enter_hunt();
        send_char(8'h16, 8);
        check("R6 internal disabled", hunting, 1);
        check("R6 no syndet", syndet, 0);
        @(negedge clk); ext_sync_in = 1'b1;
        @(negedge clk);
        check("R6 ext ends hunt", hunting, 0);
        check("R6 ext syndet", syndet, 1);
        ext_sync_in = 1'b0;
        send_char(8'h5A, 8);
        check("R8 ext framed strobe", char_strobe, 1);
        check("R8 ext framed data", char_data, 8'h5A);
        // R7: set wins over read
        read_status();
        @(negedge clk); ext_sync_in = 1'b1; status_read = 1'b1;
        @(negedge clk); status_read = 1'b0; ext_sync_in = 1'b0;
        check("R7 set wins", syndet, 1);
        read_status();
        check("R7 cleared again", syndet, 0);

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule